// File: doc/BRIEF.md
# DRAM Channel Selector and Address Normalizer

This block sits behind the node-level address decoder of a memory subsystem. It takes a system address that is already known to belong to this node, plus the node's mapping parameters and the controller-select configuration. From these it picks one of two DRAM channels and turns the system address into a dense address for that channel. Three steps make the channel address. First the right base offset is subtracted. Then the bits used for node interleaving are squeezed out. Then the bit used for channel interleaving is squeezed out.

A request is presented for one cycle with `req_vld`, together with its address and configuration. The answer shows up on `rsp_vld`, `rsp_chan` and `rsp_addr` exactly two clock edges later. Requests may be issued back to back. The response registers keep their last value while no new result arrives. Chip-select matching happens further downstream and is not part of this block.

Top module: `dram_chsel_norm`

## Requirements
- R1: While reset is asserted and for the cycles right after its release, `rsp_vld` is 0 and `rsp_chan`/`rsp_addr` read 0.
- R2: `rsp_vld` is high on exactly the second rising edge after each edge that sampled `req_vld` high, and requests may arrive on every cycle.
- R3: When `gang_en` is 1, the channel is address bit 3, and no channel-interleave bit is removed.
- R4: The high range is selected when `hr_en` is 1, `gang_en` is 0 and the address is at least `sel_base`×2^27. In the high range the channel is `hr_chan` and no channel-interleave bit is removed.
- R5: With `cil_en`=1 and `cil_mode`=0 (outside the high range and not ganged), the channel is address bit 6 and bit 6 is removed from the channel address.
- R6: With `cil_en`=1 and `cil_mode` 2 or 3, the channel is the XOR-reduction of address bits 20:16 XORed with address bit 6 (mode 2) or bit 9 (mode 3). Bit 6 (mode 2) or bit 9 (mode 3) is removed.
- R7: With `cil_en`=1 and `cil_mode`=1, the channel is address bit 12+`node_ilog`, and bit 12 of the node-squeezed address is removed.
- R8: With channel interleave off and no high range, the channel is the inverse of `hr_chan` when `hr_en` is 1, otherwise channel 0.
- R9: In the high range, the subtracted offset is `hole_ofs` when `sel_base`×2^27 < `hole_base`, `hole_vld` is 1 and the address is at least 4 GiB. Otherwise it is `sel_ofs`×2^26.
- R10: Outside the high range, the subtracted offset is `hole_ofs` when `hole_vld` is 1 and the address is at least 4 GiB. Otherwise it is `dram_base`.
- R11: After the subtraction, `node_ilog` bits starting at bit 12 are removed (bits 11:0 kept, higher bits shifted down). This happens before any channel-interleave bit is removed.
- R12: When no result is delivered on an edge, `rsp_chan` and `rsp_addr` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | 1 | Request strobe |
| req_addr | input | AW | System address to translate |
| node_ilog | input | ILW | Number of node-interleave address bits (0..3) |
| dram_base | input | AW | Node DRAM base byte address |
| hole_base | input | AW | Memory hole base byte address |
| hole_ofs | input | AW | Offset applied to addresses hoisted above 4 GiB |
| hole_vld | input | 1 | Memory hole is in use |
| hr_en | input | 1 | High address range enable |
| hr_chan | input | 1 | Channel owning the high range |
| cil_en | input | 1 | Channel interleave enable |
| gang_en | input | 1 | Ganged (128-bit) channel mode |
| cil_mode | input | 2 | Channel interleave mode: 0 bit 6, 1 bit 12+ilog, 2 hash with bit 6, 3 hash with bit 9 |
| sel_base | input | AW-27 | High range start, 128 MiB units |
| sel_ofs | input | AW-26 | High range offset, 64 MiB units |
| rsp_vld | output | 1 | Result strobe, two edges after the request |
| rsp_chan | output | 1 | Selected channel |
| rsp_addr | output | AW | Normalized channel address |

## Verification
One request can need both node-interleave removal and channel-interleave removal. The order matters, because the mode-1 channel squeeze drops bit 12 of the address that the node squeeze has already shifted. The bench provokes this by setting a nonzero `node_ilog` together with each channel-interleave mode, in directed cases and in random traffic. A behavioural model applies the subtraction, then the node squeeze, then the channel squeeze, one bit at a time, and compares the result every clock. The hole-offset choice inside the high range is provoked in the same way: both `sel_base` and `hole_base` sit near the address and the address is placed across the 4 GiB line.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  // channel interleave modes; the encoding is decoded bitwise by the datapath
  typedef enum logic [1:0] {
    CIL_BIT6  = 2'd0,
    CIL_BITHI = 2'd1,
    CIL_HASH6 = 2'd2,
    CIL_HASH9 = 2'd3
  } cil_mode_e;

  // controller-select configuration bundle
  typedef struct packed {
    logic      hr_en;
    logic      hr_chan;
    logic      cil_en;
    logic      gang_en;
    cil_mode_e mode;
  } dcs_cfg_t;

  localparam int PAGE_LSB  = 12;  // node-interleave bits start here
  localparam int GIG4_BIT  = 32;  // first bit at or above 4 GiB
  localparam int SEL_SHIFT = 27;  // 128 MiB granule
  localparam int OFS_SHIFT = 26;  // 64 MiB granule
  localparam int HASH_LO   = 16;
  localparam int HASH_HI   = 20;

endpackage

// File: rtl/dcs_route.sv
module dcs_route
  import dcs_pkg::*;
#(
  parameter int AW  = 48,
  parameter int ILW = 2
) (
  input  logic [AW-1:0]           addr,
  input  logic [ILW-1:0]          ilog,
  input  dcs_cfg_t                cfg,
  input  logic [AW-SEL_SHIFT-1:0] sel_base,
  output logic                    hi_sel,
  output logic                    chan
);

  localparam int NCAND = 1 << ILW;

  logic [AW-1:0]    sel_base_b;
  logic [NCAND-1:0] node_bit;
  logic             hash_par;
  logic             hash_low;

  assign sel_base_b = {sel_base, {SEL_SHIFT{1'b0}}};

  // channel bit just above the node-interleave field, one per ilog value
  for (genvar k = 0; k < NCAND; k++) begin : g_nbit
    assign node_bit[k] = addr[PAGE_LSB + k];
  end

  assign hash_par = ^addr[HASH_HI:HASH_LO];
  assign hash_low = cfg.mode[0] ? addr[9] : addr[6];

  always_comb begin
    hi_sel = cfg.hr_en && !cfg.gang_en && (addr >= sel_base_b);
    if (cfg.gang_en) begin
      chan = addr[3];
    end else if (hi_sel) begin
      chan = cfg.hr_chan;
    end else if (cfg.cil_en && (cfg.mode == CIL_BIT6)) begin
      chan = addr[6];
    end else if (cfg.cil_en && cfg.mode[1]) begin
      chan = hash_par ^ hash_low;
    end else if (cfg.cil_en) begin
      chan = node_bit[ilog];
    end else if (cfg.hr_en) begin
      chan = !cfg.hr_chan;
    end else begin
      chan = 1'b0;
    end
  end

endmodule

// File: rtl/dcs_offset.sv
module dcs_offset
  import dcs_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic [AW-1:0]           addr,
  input  logic                    hi_sel,
  input  logic [AW-1:0]           dram_base,
  input  logic [AW-1:0]           hole_base,
  input  logic [AW-1:0]           hole_ofs,
  input  logic                    hole_vld,
  input  logic [AW-SEL_SHIFT-1:0] sel_base,
  input  logic [AW-OFS_SHIFT-1:0] sel_ofs,
  output logic [AW-1:0]           ofs
);

  logic [AW-1:0] sel_base_b;
  logic [AW-1:0] sel_ofs_b;
  logic          above4g;
  logic          hoisted;

  assign sel_base_b = {sel_base, {SEL_SHIFT{1'b0}}};
  assign sel_ofs_b  = {sel_ofs, {OFS_SHIFT{1'b0}}};
  assign above4g    = |addr[AW-1:GIG4_BIT];
  assign hoisted    = hole_vld && above4g;

  always_comb begin
    if (hi_sel) begin
      ofs = (hoisted && (sel_base_b < hole_base)) ? hole_ofs : sel_ofs_b;
    end else begin
      ofs = hoisted ? hole_ofs : dram_base;
    end
  end

endmodule

// File: rtl/dcs_squeeze.sv
module dcs_squeeze
  import dcs_pkg::*;
#(
  parameter int AW  = 48,
  parameter int ILW = 2
) (
  input  logic [AW-1:0]  din,
  input  logic [ILW-1:0] ilog,
  input  logic           cil_on,
  input  cil_mode_e      mode,
  output logic [AW-1:0]  dout
);

  localparam int NCAND = 1 << ILW;

  function automatic logic [AW-1:0] drop_bit(input logic [AW-1:0] x, input int p);
    logic [AW-1:0] keep;
    keep = (AW'(1) << p) - AW'(1);
    return ((x >> (p + 1)) << p) | (x & keep);
  endfunction

  logic [AW-1:0] low_page;
  logic [AW-1:0] node_cand [NCAND];
  logic [AW-1:0] node_sq;
  logic [AW-1:0] drop6;
  logic [AW-1:0] drop9;
  logic [AW-1:0] drop12;

  assign low_page = {{(AW-PAGE_LSB){1'b0}}, din[PAGE_LSB-1:0]};

  // one candidate per possible node-interleave width
  for (genvar k = 0; k < NCAND; k++) begin : g_node
    assign node_cand[k] = ((din >> (PAGE_LSB + k)) << PAGE_LSB) | low_page;
  end

  assign node_sq = node_cand[ilog];
  assign drop6   = drop_bit(node_sq, 6);
  assign drop9   = drop_bit(node_sq, 9);
  assign drop12  = drop_bit(node_sq, PAGE_LSB);

  always_comb begin
    if (!cil_on) begin
      dout = node_sq;
    end else if (!mode[0]) begin
      dout = drop6;
    end else if (mode == CIL_BITHI) begin
      dout = drop12;
    end else begin
      dout = drop9;
    end
  end

endmodule

// File: rtl/dram_chsel_norm.sv
module dram_chsel_norm
  import dcs_pkg::*;
#(
  parameter int AW  = 48,
  parameter int ILW = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_vld,
  input  logic [AW-1:0]           req_addr,
  input  logic [ILW-1:0]          node_ilog,
  input  logic [AW-1:0]           dram_base,
  input  logic [AW-1:0]           hole_base,
  input  logic [AW-1:0]           hole_ofs,
  input  logic                    hole_vld,
  input  logic                    hr_en,
  input  logic                    hr_chan,
  input  logic                    cil_en,
  input  logic                    gang_en,
  input  logic [1:0]              cil_mode,
  input  logic [AW-SEL_SHIFT-1:0] sel_base,
  input  logic [AW-OFS_SHIFT-1:0] sel_ofs,
  output logic                    rsp_vld,
  output logic                    rsp_chan,
  output logic [AW-1:0]           rsp_addr
);

  // ---------------- reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign arst_n = rst_sync[1];

  // ---------------- stage 1: route and offset choice
  dcs_cfg_t cfg;
  logic     hi_sel;
  logic     chan_d;
  logic [AW-1:0] ofs_d;

  assign cfg.hr_en   = hr_en;
  assign cfg.hr_chan = hr_chan;
  assign cfg.cil_en  = cil_en;
  assign cfg.gang_en = gang_en;
  assign cfg.mode    = cil_mode_e'(cil_mode);

  dcs_route #(.AW(AW), .ILW(ILW)) u_route (
    .addr     (req_addr),
    .ilog     (node_ilog),
    .cfg      (cfg),
    .sel_base (sel_base),
    .hi_sel   (hi_sel),
    .chan     (chan_d)
  );

  dcs_offset #(.AW(AW)) u_offset (
    .addr      (req_addr),
    .hi_sel    (hi_sel),
    .dram_base (dram_base),
    .hole_base (hole_base),
    .hole_ofs  (hole_ofs),
    .hole_vld  (hole_vld),
    .sel_base  (sel_base),
    .sel_ofs   (sel_ofs),
    .ofs       (ofs_d)
  );

  logic            s1_vld;
  logic            s1_chan;
  logic            s1_cil;
  cil_mode_e       s1_mode;
  logic [ILW-1:0]  s1_ilog;
  logic [AW-1:0]   s1_addr;
  logic [AW-1:0]   s1_ofs;
  logic            s1_cil_d;

  assign s1_cil_d = cil_en && !hi_sel && !gang_en;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_vld  <= 1'b0;
      s1_chan <= 1'b0;
      s1_cil  <= 1'b0;
      s1_mode <= CIL_BIT6;
      s1_ilog <= '0;
      s1_addr <= '0;
      s1_ofs  <= '0;
    end else begin
      s1_vld <= req_vld;
      if (req_vld) begin
        s1_chan <= chan_d;
        s1_cil  <= s1_cil_d;
        s1_mode <= cfg.mode;
        s1_ilog <= node_ilog;
        s1_addr <= req_addr;
        s1_ofs  <= ofs_d;
      end
    end
  end

  // ---------------- stage 2: subtract and squeeze
  logic [AW-1:0] diff;
  logic [AW-1:0] norm_d;

  assign diff = s1_addr - s1_ofs;

  dcs_squeeze #(.AW(AW), .ILW(ILW)) u_squeeze (
    .din    (diff),
    .ilog   (s1_ilog),
    .cil_on (s1_cil),
    .mode   (s1_mode),
    .dout   (norm_d)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rsp_vld  <= 1'b0;
      rsp_chan <= 1'b0;
      rsp_addr <= '0;
    end else begin
      rsp_vld <= s1_vld;
      if (s1_vld) begin
        rsp_chan <= s1_chan;
        rsp_addr <= norm_d;
      end
    end
  end

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int AW = 48
) (
  input logic                clk,
  input logic                arst_n,
  input logic                req_vld,
  input logic [AW-1:0]       req_addr,
  input logic [AW-1:0]       dram_base,
  input logic [AW-27-1:0]    sel_base,
  input logic                hole_vld,
  input logic                hr_en,
  input logic                hr_chan,
  input logic                cil_en,
  input logic                gang_en,
  input logic [1:0]          cil_mode,
  input logic [1:0]          node_ilog,
  input logic                s1_vld,
  input logic                rsp_vld,
  input logic                rsp_chan,
  input logic [AW-1:0]       rsp_addr
);

  logic [1:0] vpipe;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) vpipe <= 2'b00;
    else         vpipe <= {vpipe[0], req_vld};
  end

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!arst_n)
    rsp_vld == vpipe[1]); // R2

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    !s1_vld |=> ($stable(rsp_chan) && $stable(rsp_addr))); // R12

  AST_GANG_CHAN: assert property (@(posedge clk) disable iff (!arst_n)
    (req_vld && gang_en) |-> ##2 (rsp_chan == $past(req_addr[3], 2))); // R3

  AST_HIRNG_CHAN: assert property (@(posedge clk) disable iff (!arst_n)
    (req_vld && hr_en && !gang_en && (req_addr >= {sel_base, 27'b0}))
      |-> ##2 (rsp_chan == $past(hr_chan, 2))); // R4

  AST_HASH9_CHAN: assert property (@(posedge clk) disable iff (!arst_n)
    (req_vld && cil_en && !gang_en && !hr_en && (cil_mode == 2'd3))
      |-> ##2 (rsp_chan == $past((^req_addr[20:16]) ^ req_addr[9], 2))); // R6

  AST_PLAIN_BASE: assert property (@(posedge clk) disable iff (!arst_n)
    (req_vld && !cil_en && !gang_en && !hr_en && !hole_vld && (node_ilog == 2'd0))
      |-> ##2 (!rsp_chan && (rsp_addr == $past(req_addr - dram_base, 2)))); // R10

endmodule

bind dram_chsel_norm dcs_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .arst_n    (arst_n),
  .req_vld   (req_vld),
  .req_addr  (req_addr),
  .dram_base (dram_base),
  .sel_base  (sel_base),
  .hole_vld  (hole_vld),
  .hr_en     (hr_en),
  .hr_chan   (hr_chan),
  .cil_en    (cil_en),
  .gang_en   (gang_en),
  .cil_mode  (cil_mode),
  .node_ilog (node_ilog[1:0]),
  .s1_vld    (s1_vld),
  .rsp_vld   (rsp_vld),
  .rsp_chan  (rsp_chan),
  .rsp_addr  (rsp_addr)
);

// File: tb/sim_dram_chsel_norm.sv
`timescale 1ns/1ps
module sim_dram_chsel_norm;

  localparam int AW = 48;
  localparam longint unsigned MASK = (64'd1 << AW) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_vld = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [1:0]        node_ilog = '0;
  logic [AW-1:0]     dram_base = '0;
  logic [AW-1:0]     hole_base = '0;
  logic [AW-1:0]     hole_ofs = '0;
  logic              hole_vld = 1'b0;
  logic              hr_en = 1'b0;
  logic              hr_chan = 1'b0;
  logic              cil_en = 1'b0;
  logic              gang_en = 1'b0;
  logic [1:0]        cil_mode = '0;
  logic [AW-28:0]    sel_base = '0;
  logic [AW-27:0]    sel_ofs = '0;
  logic              rsp_vld;
  logic              rsp_chan;
  logic [AW-1:0]     rsp_addr;

  always #2.5 clk = ~clk;

  dram_chsel_norm #(.AW(AW), .ILW(2)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model pipeline
  bit m1_v, m2_v, m1_c, m2_c;
  longint unsigned m1_a, m2_a;
  string m1_tc, m2_tc, m1_ta, m2_ta;

  function automatic longint unsigned drop(longint unsigned x, int p);
    longint unsigned lo;
    lo = x & ((64'd1 << p) - 1);
    return ((x >> (p + 1)) << p) | lo;
  endfunction

  task automatic model_eval(output bit ch, output longint unsigned na,
                            output string tc, output string ta);
    longint unsigned a, ofs, d, selb;
    bit hi, hoist;
    int pos;
    a     = longint'(req_addr);
    selb  = longint'(sel_base) << 27;
    hi    = hr_en && !gang_en && (a >= selb);
    hoist = hole_vld && (a >= 64'h1_0000_0000);
    if (gang_en) begin ch = a[3]; tc = "R3"; end
    else if (hi) begin ch = hr_chan; tc = "R4"; end
    else if (cil_en && cil_mode == 0) begin ch = a[6]; tc = "R5"; end
    else if (cil_en && cil_mode[1]) begin
      ch = ($countones(a[20:16]) % 2 == 1) ^ (cil_mode[0] ? a[9] : a[6]);
      tc = "R6";
    end
    else if (cil_en) begin ch = a[12 + node_ilog]; tc = "R7"; end
    else if (hr_en) begin ch = !hr_chan; tc = "R8"; end
    else begin ch = 1'b0; tc = "R8"; end
    if (hi) begin
      ofs = (hoist && selb < longint'(hole_base)) ? longint'(hole_ofs)
                                                  : (longint'(sel_ofs) << 26);
      ta = "R9";
    end else begin
      ofs = hoist ? longint'(hole_ofs) : longint'(dram_base);
      ta = "R10";
    end
    d = (a - ofs) & MASK;
    for (int i = 0; i < node_ilog; i++) d = drop(d, 12);
    if (node_ilog != 0) ta = "R11";
    if (cil_en && !hi && !gang_en) begin
      if (!cil_mode[0]) pos = 6;
      else if (cil_mode == 1) pos = 12;
      else pos = 9;
      d = drop(d, pos);
      ta = tc;
    end
    na = d & MASK;
  endtask

  task automatic chk(bit ok, string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, then advance the model by one edge
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk(rsp_vld == 1'b0, "R1", 64'(rsp_vld), 0);
        chk(rsp_addr == '0 && rsp_chan == 1'b0, "R1", longint'(rsp_addr), 0);
        m1_v = 0; m2_v = 0; m1_c = 0; m2_c = 0; m1_a = 0; m2_a = 0;
      end else begin
        chk(rsp_vld == m2_v, "R2", 64'(rsp_vld), 64'(m2_v));
        if (m2_v) begin
          chk(rsp_chan == m2_c, m2_tc, 64'(rsp_chan), 64'(m2_c));
          chk(longint'(rsp_addr) == m2_a, m2_ta, longint'(rsp_addr), m2_a);
        end else begin
          chk(rsp_chan == m2_c && longint'(rsp_addr) == m2_a, "R12",
              longint'(rsp_addr), m2_a);
        end
        m2_v = m1_v;
        if (m1_v) begin m2_c = m1_c; m2_a = m1_a; m2_tc = m1_tc; m2_ta = m1_ta; end
        m1_v = req_vld;
        if (req_vld) model_eval(m1_c, m1_a, m1_tc, m1_ta);
      end
    end
  end

  task automatic issue(longint unsigned a, int il, longint unsigned db,
                       longint unsigned hb, longint unsigned ho, bit hv,
                       bit hre, bit hch, bit cie, bit gang, int md,
                       longint unsigned sb, longint unsigned so, int gap);
    @(posedge clk); #1;
    req_vld = 1; req_addr = AW'(a); node_ilog = 2'(il);
    dram_base = AW'(db); hole_base = AW'(hb); hole_ofs = AW'(ho); hole_vld = hv;
    hr_en = hre; hr_chan = hch; cil_en = cie; gang_en = gang; cil_mode = 2'(md);
    sel_base = (AW-27)'(sb); sel_ofs = (AW-26)'(so);
    for (int g = 0; g < gap; g++) begin
      @(posedge clk); #1;
      req_vld = 0;
      req_addr = AW'({$urandom, $urandom});  // must be ignored
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    longint unsigned a;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    // R3 ganged, bit 3 and no channel squeeze
    issue(64'h0000_1234_5678, 0, 64'h0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 2);
    issue(64'h0000_1234_5670, 1, 64'h1000_0000, 0, 0, 0, 1, 1, 1, 1, 0, 0, 0, 0);
    // R4/R9 high range, below and above 4 GiB with hole
    issue(64'h0000_4000_0000, 0, 0, 64'hC000_0000, 64'h4000_0000, 1, 1, 1, 1, 0, 0, 4, 2, 1);
    issue(64'h0001_4000_0000, 0, 0, 64'hC000_0000, 64'h4000_0000, 1, 1, 0, 1, 0, 0, 4, 2, 0);
    issue(64'h0001_4000_0000, 0, 0, 64'h1000_0000, 64'h4000_0000, 1, 1, 0, 1, 0, 0, 4, 2, 2);
    // R5 / R6 / R7 each mode, with node interleave (R11) combined
    for (int md = 0; md < 4; md++)
      for (int il = 0; il < 4; il++) begin
        issue(64'h0000_0013_5EC0 + longint'(md * 8 + il) * 64'h1_1040, il,
              64'h0, 0, 0, 0, 0, 0, 1, 0, md, 1000, 0, il % 2);
      end
    // R8 inverted high channel below base, and channel 0
    issue(64'h0000_0800_0040, 0, 64'h400_0000, 0, 0, 0, 1, 1, 0, 0, 0, 64, 0, 1);
    issue(64'h0000_0800_0040, 0, 64'h400_0000, 0, 0, 0, 0, 1, 0, 0, 0, 64, 0, 1);
    // R10 hole offset outside high range, and exactly at 4 GiB
    issue(64'h0001_0000_0000, 0, 0, 64'hC000_0000, 64'h4000_0000, 1, 0, 0, 0, 0, 0, 0, 0, 1);
    issue(64'h0000_FFFF_FFF0, 0, 64'h100, 64'hC000_0000, 64'h4000_0000, 1, 0, 0, 0, 0, 0, 0, 0, 3);
    // random traffic, back to back and with gaps
    for (int n = 0; n < 3000; n++) begin
      a = {$urandom, $urandom} & MASK;
      if ($urandom % 2) a = a & 64'h1_FFFF_FFFF;
      issue(a, $urandom % 4, ({$urandom, $urandom} & 64'hFFFF_FFFF) % (a + 1),
            64'h8000_0000 + ($urandom % 64'h8000_0000), {$urandom} & 64'hFFFF_FF00,
            $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
            ($urandom % 4) == 0, $urandom % 4,
            (a >> 27) + ($urandom % 3) - 1, $urandom % 4096, $urandom % 3 == 0 ? 1 : 0);
    end
    @(posedge clk); #1 req_vld = 0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule